// File: doc/BRIEF.md
# Dual UART Register Interface

This block is a byte-wide I/O register front end for two independent serial transmitter/receiver pairs that share one set of three ports. A select bit in the control port picks which UART every access reaches. Software sends a byte by writing the transmit port, reads one received byte per read of the receive port, and reads a status byte that reports whether the receive queue holds data, whether it is full, and whether the transmitter is busy.

Each UART has a 17-bit baud divisor, loaded in pieces. The top 3 bits come through the control port. The lower 14 bits come as two 7-bit halves through writes to the receive port, and data bit 7 of each write says which half it is. One bit lasts exactly as many system clocks as the divisor value. Frames are 8N1: one low start bit, eight data bits least significant first, and one high stop bit. There is no transmit buffer, so a write while a frame is going out is lost. Each receiver feeds an 8-entry FIFO.

Top module: `dual_uart_regs`

## Requirements
- R1: Control write bit 6 selects the UART that all port accesses reach: 0 selects UART 0 and 1 selects UART 1. A control read returns the select in bit 6 and divisor bits 16:14 of the selected UART in bits 2:0, with all other bits zero. Transmit writes and status reads never reach the unselected UART.
- R2: A control write with bit 4 set loads its bits 2:0 into divisor bits 16:14 of the UART named by its bit 6. With bit 4 clear, those divisor bits are unchanged.
- R3: A write to the receive port (address 1) with bit 7 set loads bits 6:0 into divisor bits 13:7. With bit 7 clear, it loads bits 6:0 into divisor bits 6:0. Both act on the selected UART.
- R4: After reset both divisors are 243, UART 0 is selected, both serial outputs are high, and status reads 0x00.
- R5: A write to the transmit port (address 0) drives, from the next clock edge, a low start bit, the 8 data bits LSB first, and a high stop bit. Each bit lasts exactly divisor clocks.
- R6: A transmit write that arrives while a frame is in progress is dropped and does not disturb that frame.
- R7: A status read (address 0) returns bit 2 = receive FIFO full, bit 1 = transmitter busy, bit 0 = receive data waiting, and zeros in bits 7:3.
- R8: The receiver detects a falling edge after a two-flop synchroniser and samples at mid-bit. It stores a byte whose stop bit reads high in its UART's FIFO, in order.
- R9: The receive FIFO holds 8 bytes. A byte arriving while it is full is discarded.
- R10: Reading the receive port with an empty FIFO returns 0x00 and changes no state.
- R11: Read data (address 2 = control) appears on the read bus one clock after the read strobe, and a receive port read pops exactly one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_addr | input | 2 | 0 = transmit/status, 1 = receive/divisor, 2 = control |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| uart_rxd | input | 2 | Serial inputs, bit i for UART i |
| uart_txd | output | 2 | Serial outputs, bit i for UART i |

## Verification
The assertions assume that the read and write strobes are single-cycle pulses and are never both high. They also assume that a divisor is at least 2 while its UART is active, which keeps the mid-bit counter well defined. The bench drives each access as a one-cycle pulse set between clock edges. It loads only divisors of 8, 11, 131 and the reset value 243. It drives serial input frames whose bit length matches the divisor of the receiving UART, so receiver sampling is only checked inside the timing it is built for.

// File: rtl/duart_pkg.sv
package duart_pkg;
  localparam int PRESC_W = 17;
  localparam int DATA_W  = 8;

  typedef enum logic [1:0] {
    PORT_TXD = 2'd0,
    PORT_RXD = 2'd1,
    PORT_CTL = 2'd2
  } port_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/duart_tx.sv
module duart_tx #(
  parameter int PW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] presc,
  input  logic          start,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy
);
  localparam int BITS_AFTER_START = DW + 1;
  localparam int BW = $clog2(BITS_AFTER_START + 1);

  logic [PW-1:0] cnt;
  logic [BW-1:0] left;
  logic [DW:0]   shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd   <= 1'b1;
      busy  <= 1'b0;
      cnt   <= '0;
      left  <= '0;
      shreg <= '1;
    end else if (!busy) begin
      if (start) begin
        txd   <= 1'b0;
        busy  <= 1'b1;
        shreg <= {1'b1, data};
        left  <= BW'(BITS_AFTER_START);
        cnt   <= presc - 1'b1;
      end
    end else if (cnt == '0) begin
      if (left == '0) begin
        busy <= 1'b0;
      end else begin
        txd   <= shreg[0];
        shreg <= {1'b1, shreg[DW:1]};
        left  <= left - 1'b1;
        cnt   <= presc - 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd); // R5

  AST_TX_DROP: assert property (@(posedge clk) disable iff (rst)
    (start && busy && cnt != '0) |=> $stable(shreg) && $stable(left)); // R6
endmodule

// File: rtl/duart_rx.sv
module duart_rx #(
  parameter int PW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] presc,
  input  logic          rxd,
  output logic          push,
  output logic [DW-1:0] data
);
  import duart_pkg::*;
  localparam int BW = $clog2(DW + 1);

  logic          s1, s2;
  rx_state_e     st;
  logic [PW-1:0] cnt;
  logic [BW-1:0] nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      st    <= RX_IDLE;
      cnt   <= '0;
      nbits <= '0;
      data  <= '0;
      push  <= 1'b0;
    end else begin
      s1   <= rxd;
      s2   <= s1;
      push <= 1'b0;
      case (st)
        RX_IDLE: if (!s2) begin
          st  <= RX_START;
          cnt <= (presc >> 1) - 1'b1;
        end
        RX_START: if (cnt == '0) begin
          if (!s2) begin
            st    <= RX_DATA;
            cnt   <= presc - 1'b1;
            nbits <= '0;
          end else begin
            st <= RX_IDLE;
          end
        end else cnt <= cnt - 1'b1;
        RX_DATA: if (cnt == '0) begin
          data  <= {s2, data[DW-1:1]};
          nbits <= nbits + 1'b1;
          cnt   <= presc - 1'b1;
          if (nbits == BW'(DW - 1)) st <= RX_STOP;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          push <= s2;
          st   <= RX_IDLE;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  AST_RX_ONE_PUSH: assert property (@(posedge clk) disable iff (rst)
    push |=> !push); // R8
endmodule

// File: rtl/duart_fifo.sv
module duart_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wptr, rptr;
  logic [AW:0]   count;

  assign count = wptr - rptr;
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign head  = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH)); // R9

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty); // R10
endmodule

// File: rtl/dual_uart_regs.sv
module dual_uart_regs #(
  parameter int FIFO_DEPTH  = 8,
  parameter int PRESC_RESET = 243
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [1:0] io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic [1:0] uart_rxd,
  output logic [1:0] uart_txd
);
  import duart_pkg::*;
  localparam int NCH = 2;
  localparam int PW  = PRESC_W;
  localparam int DW  = DATA_W;
  localparam int HI  = PW - 14;

  logic          sel;
  logic [PW-1:0] presc [NCH];
  logic [NCH-1:0] busy, empty, full;
  logic [DW-1:0]  head [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= 1'b0;
      for (int i = 0; i < NCH; i++) presc[i] <= PW'(PRESC_RESET);
    end else if (io_wr) begin
      if (io_addr == PORT_CTL) begin
        sel <= io_wdata[6];
        if (io_wdata[4]) presc[io_wdata[6]][PW-1:14] <= io_wdata[HI-1:0];
      end else if (io_addr == PORT_RXD) begin
        if (io_wdata[7]) presc[sel][13:7] <= io_wdata[6:0];
        else             presc[sel][6:0]  <= io_wdata[6:0];
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          mine, rx_push;
    logic [DW-1:0] rx_byte;
    assign mine = (sel == 1'(i));

    duart_tx #(.PW(PW), .DW(DW)) u_tx (
      .clk(clk), .rst(rst), .presc(presc[i]),
      .start(io_wr && io_addr == PORT_TXD && mine),
      .data(io_wdata), .txd(uart_txd[i]), .busy(busy[i]));

    duart_rx #(.PW(PW), .DW(DW)) u_rx (
      .clk(clk), .rst(rst), .presc(presc[i]), .rxd(uart_rxd[i]),
      .push(rx_push), .data(rx_byte));

    duart_fifo #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_fifo (
      .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_byte),
      .pop(io_rd && io_addr == PORT_RXD && mine),
      .head(head[i]), .empty(empty[i]), .full(full[i]));

    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (rst)
      (io_wr && io_addr == PORT_CTL && !io_wdata[4])
      |=> presc[i][PW-1:14] == $past(presc[i][PW-1:14])); // R2
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else if (io_rd) begin
      case (io_addr)
        PORT_TXD: io_rdata <= {5'b0, full[sel], busy[sel], !empty[sel]};
        PORT_RXD: io_rdata <= empty[sel] ? 8'h00 : head[sel];
        PORT_CTL: io_rdata <= {1'b0, sel, 3'b0, presc[sel][PW-1:14]};
        default:  io_rdata <= 8'h00;
      endcase
    end
  end

  AST_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == PORT_RXD && empty[sel]) |=> io_rdata == 8'h00); // R10
endmodule

// File: tb/dual_uart_regs_tb.sv
`timescale 1ns/1ps
module dual_uart_regs_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [1:0] io_addr = 2'd0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic [1:0] uart_rxd = 2'b11;
  logic [1:0] uart_txd;
  int checks = 0, failures = 0;
  bit done = 0;

  localparam logic [1:0] A_TX = 2'd0, A_RX = 2'd1, A_CTL = 2'd2;

  always #4 clk = ~clk;

  dual_uart_regs u_dut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .uart_rxd(uart_rxd), .uart_txd(uart_txd));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); io_rd = 1'b1; io_addr = a;
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  // Called at the negedge that follows the accepted transmit write plus 'late' cycles.
  task automatic tx_frame(input int ch, input logic [7:0] b, input int p, input int late, input string tag);
    for (int k = 0; k < 10; k++) begin
      logic e;
      repeat (k == 0 ? p/2 - late : p) @(negedge clk);
      e = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
      check(tag, {7'b0, uart_txd[ch]}, {7'b0, e});
      check("R1 idle other txd", {7'b0, uart_txd[1-ch]}, 8'h01);
    end
    repeat (p) @(negedge clk);
  endtask

  task automatic rx_send(input int ch, input logic [7:0] b, input int p);
    @(negedge clk); uart_rxd[ch] = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      uart_rxd[ch] = b[i];
      repeat (p) @(negedge clk);
    end
    uart_rxd[ch] = 1'b1;
    repeat (p + 4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] sent [9];
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R4 reset state
    check("R4 txd idle", {6'b0, uart_txd}, 8'h03);
    rd(A_CTL, v);  check("R4 ctl reset", v, 8'h00);
    rd(A_TX, v);   check("R4 status reset", v, 8'h00);
    rd(A_RX, v);   check("R10 empty read", v, 8'h00);
    // R4 reset divisor 243 on UART 0
    wr(A_TX, 8'h3C); tx_frame(0, 8'h3C, 243, 0, "R4 R5 divisor 243 frame");
    // R2 upper divisor bits
    wr(A_CTL, 8'h07); rd(A_CTL, v); check("R2 bit4 clear holds", v, 8'h00);
    wr(A_CTL, 8'h15); rd(A_CTL, v); check("R2 bit4 set loads", v, 8'h05);
    wr(A_CTL, 8'h10); rd(A_CTL, v); check("R2 reload zero", v, 8'h00);
    // R3 both halves: 1*128 + 3 = 131
    wr(A_RX, 8'h81); wr(A_RX, 8'h03);
    wr(A_TX, 8'hC6); tx_frame(0, 8'hC6, 131, 0, "R3 divisor 131 frame");
    wr(A_RX, 8'h80); wr(A_RX, 8'h08);
    // R1 select UART 1, divisor 11
    wr(A_CTL, 8'h50); rd(A_CTL, v); check("R1 ctl select", v, 8'h40);
    wr(A_RX, 8'h80); wr(A_RX, 8'h0B);
    for (int n = 0; n < 6; n++) begin
      logic [7:0] b;
      b = 8'(n * 51 + 17);
      wr(A_TX, b); tx_frame(1, b, 11, 0, "R5 uart1 frame");
    end
    wr(A_CTL, 8'h00);
    for (int n = 0; n < 6; n++) begin
      logic [7:0] b;
      b = 8'(n * 73 + 1);
      wr(A_TX, b); tx_frame(0, b, 8, 0, "R5 uart0 frame");
    end
    wr(A_TX, 8'h00); tx_frame(0, 8'h00, 8, 0, "R5 all zero");
    wr(A_TX, 8'hFF); tx_frame(0, 8'hFF, 8, 0, "R5 all one");
    // R6 write during frame dropped
    wr(A_TX, 8'hA5); wr(A_TX, 8'h5A); tx_frame(0, 8'hA5, 8, 1, "R6 drop");
    // R7 busy flag
    wr(A_TX, 8'h11); rd(A_TX, v); check("R7 busy", v, 8'h02);
    repeat (90) @(negedge clk);
    rd(A_TX, v); check("R7 idle", v, 8'h00);
    // R1 receive on UART 0 not visible while UART 1 selected
    wr(A_CTL, 8'h40);
    rx_send(0, 8'h6E, 8);
    rd(A_TX, v); check("R1 other status hidden", v, 8'h00);
    // R8 R9 fill UART 1
    for (int n = 0; n < 9; n++) begin
      sent[n] = 8'(n * 37 + 5);
      rx_send(1, sent[n], 11);
      rd(A_TX, v);
      if (n == 0) check("R7 R8 data waiting", v, 8'h01);
      if (n >= 7) check("R9 full flag", v, 8'h05);
    end
    for (int n = 0; n < 8; n++) begin
      rd(A_RX, v); check("R8 R11 fifo order", v, sent[n]);
    end
    rd(A_TX, v); check("R9 overflow discarded", v, 8'h00);
    rd(A_RX, v); check("R10 empty read zero", v, 8'h00);
    rd(A_TX, v); check("R10 no state change", v, 8'h00);
    wr(A_CTL, 8'h00);
    rd(A_TX, v); check("R1 uart0 status", v, 8'h01);
    rd(A_RX, v); check("R1 R8 uart0 byte", v, 8'h6E);
    rd(A_TX, v); check("R11 single pop", v, 8'h00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule